// File: doc/BRIEF.md
# Security Attribution Region Unit

This block labels every address of a 32-bit space as Secure, Non-secure or Non-secure-callable. Software programs a small bank of address windows through a 32-bit register bus. Each window has a base, an inclusive limit, an enable flag and a callable flag. One select register picks which window the base and limit registers refer to, so every window is reached through the same two offsets. A separate lookup port takes an address and returns its label combinationally, in the same cycle.

Two flags in the control register set the global behaviour. When the unit is switched off, one flag decides whether the whole space looks Secure or Non-secure. When it is switched on, an address that falls in exactly one enabled window takes that window's label. An address in no window, or in more than one, is Secure.

The bus side is a two-state handshake machine with the states IDLE and RESP. In IDLE it raises `bus_ready`. A request seen with `bus_valid` takes the transition IDLE→RESP. Any write happens on that same edge, and any read data is captured on it. In RESP the machine drops `bus_ready` and raises `rsp_valid` for one cycle, then takes the transition RESP→IDLE with no condition.

Top module: `sau_attrib_unit`

## Requirements
- R1: After reset the control register, the select register and every window's flags are 0, so a lookup of any address returns Secure (`lookup_attr` = 2'b00).
- R2: The control register at offset 0x00 holds the unit enable in bit 0 and the all-non-secure flag in bit 1. Bits 31:2 are dropped on write and read as zero.
- R3: While the unit enable is 0, every lookup returns Non-secure (2'b01) if the all-non-secure flag is 1 and Secure (2'b00) if it is 0. While the unit enable is 1, the all-non-secure flag has no effect.
- R4: The type register at offset 0x04 reads 4 in bits 7:0 and zero above. Writes to it have no effect.
- R5: The select register at offset 0x08 is 8 bits wide and reads zero-extended. A write whose bits 7:0 are 4 or more is ignored.
- R6: The base register at offset 0x0C stores address bits 31:5 of the selected window. Bits 4:0 read as zero. Reads and writes act only on the window named by the select register.
- R7: The limit register at offset 0x10 stores address bits 31:5 of the selected window's limit, the callable flag in bit 1 and the window enable in bit 0. Bits 4:2 read as zero.
- R8: An enabled window contains an address when the address is at least the base with bits 4:0 cleared and at most the limit with bits 4:0 set, both bounds included.
- R9: With the unit enabled, an address in exactly one window returns Non-secure (2'b01), or Non-secure-callable (2'b10) if that window's callable flag is set. An address in no window, or in two or more windows, returns Secure (2'b00).
- R10: Reads of any other offset return zero. Writes to any other offset change no register.
- R11: A request is accepted on a clock edge where `bus_valid` and `bus_ready` are both 1. `rsp_valid` is 1 in exactly the next cycle and carries the read data (zero for writes). `bus_ready` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Request present |
| bus_ready | output | 1 | Block can accept a request (state IDLE) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle (state RESP) |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| lookup_addr | input | 32 | Address to classify |
| lookup_attr | output | 2 | 00 Secure, 01 Non-secure, 10 Non-secure-callable |

## Verification
The case that is hardest to reach from the ports is an address that two enabled windows cover at once, sitting next to addresses that only one window covers. It is not enough for that address to be Secure: both neighbours must be classified correctly as well. The bench uses the select register to program two windows that share a 128-byte stretch, then probes both edges of the shared stretch and both edges of each window. After that it turns one window off through its limit register, so the shared stretch becomes single-hit, and probes again. A rejected select write is placed just before a base access, so that a wrongly accepted select would send the base access to the wrong window.

// File: rtl/sau_pkg.sv
package sau_pkg;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned GRAN_BITS = 5;
    localparam int unsigned PAGE_W    = DATA_W - GRAN_BITS;
    localparam int unsigned OFF_W     = 5;

    localparam logic [OFF_W-1:0] OFF_CTRL  = 5'h00;
    localparam logic [OFF_W-1:0] OFF_TYPE  = 5'h04;
    localparam logic [OFF_W-1:0] OFF_SEL   = 5'h08;
    localparam logic [OFF_W-1:0] OFF_BASE  = 5'h0C;
    localparam logic [OFF_W-1:0] OFF_LIMIT = 5'h10;

    typedef enum logic [1:0] {
        ATTR_SEC  = 2'b00,
        ATTR_NSEC = 2'b01,
        ATTR_NSC  = 2'b10
    } attr_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic [PAGE_W-1:0] base;
        logic [PAGE_W-1:0] limit;
        logic              nsc;
        logic              en;
    } window_t;
endpackage

// File: rtl/sau_bus_fsm.sv
module sau_bus_fsm
    import sau_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [DATA_W-1:0] rd_data,
    output logic              bus_ready,
    output logic              wr_stb,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    bus_state_e state_q, state_d;
    logic       accept;

    assign accept = bus_valid && (state_q == BUS_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (bus_valid) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        bus_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            BUS_IDLE: bus_ready = 1'b1;
            BUS_RESP: rsp_valid = 1'b1;
            default:  bus_ready = 1'b0;
        endcase
    end

    assign wr_stb = accept && bus_write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rsp_rdata <= '0;
        else if (accept) rsp_rdata <= bus_write ? '0 : rd_data;
    end

    // R11: a response follows every accepted request
    a_r11_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready) |=> rsp_valid);
    // R11: never ready during a response cycle
    a_r11_no_ready_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !bus_ready);
    // R11: a response lasts a single cycle
    a_r11_single_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/sau_reg_bank.sv
module sau_reg_bank
    import sau_pkg::*;
#(
    parameter int unsigned NUM_WIN = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_stb,
    input  logic [OFF_W-1:0]     addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 unit_en,
    output logic                 all_ns,
    output window_t [NUM_WIN-1:0] windows
);
    localparam int unsigned SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    logic [SEL_W-1:0] sel_q;
    logic             sel_ok;

    assign sel_ok = ({24'b0, wdata[7:0]} < NUM_WIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unit_en <= 1'b0;
            all_ns  <= 1'b0;
        end else if (wr_stb && addr == OFF_CTRL) begin
            unit_en <= wdata[0];
            all_ns  <= wdata[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  sel_q <= '0;
        else if (wr_stb && addr == OFF_SEL && sel_ok) sel_q <= wdata[SEL_W-1:0];
    end

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic hit_sel;
        assign hit_sel = (sel_q == SEL_W'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                windows[g] <= '0;
            end else if (wr_stb && hit_sel) begin
                if (addr == OFF_BASE) begin
                    windows[g].base <= wdata[DATA_W-1:GRAN_BITS];
                end else if (addr == OFF_LIMIT) begin
                    windows[g].limit <= wdata[DATA_W-1:GRAN_BITS];
                    windows[g].nsc   <= wdata[1];
                    windows[g].en    <= wdata[0];
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            OFF_CTRL:  rd_data = {30'b0, all_ns, unit_en};
            OFF_TYPE:  rd_data = {24'b0, 8'(NUM_WIN)};
            OFF_SEL:   rd_data = {{(DATA_W-SEL_W){1'b0}}, sel_q};
            OFF_BASE:  rd_data = {windows[sel_q].base, 5'b0};
            OFF_LIMIT: rd_data = {windows[sel_q].limit, 3'b0,
                                  windows[sel_q].nsc, windows[sel_q].en};
            default:   rd_data = '0;
        endcase
    end

    // R5: the select register never names a missing window
    a_r5_sel_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ({{(DATA_W-SEL_W){1'b0}}, sel_q} < NUM_WIN));
    // R5: a rejected select write leaves the select unchanged
    a_r5_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && addr == OFF_SEL && wdata[7:0] >= 8'(NUM_WIN)) |=> $stable(sel_q));
    // R2: control flags only change through a control write
    a_r2_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && addr == OFF_CTRL) |=> ($stable(unit_en) && $stable(all_ns)));
endmodule

// File: rtl/sau_lookup.sv
module sau_lookup
    import sau_pkg::*;
#(
    parameter int unsigned NUM_WIN = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  unit_en,
    input  logic                  all_ns,
    input  window_t [NUM_WIN-1:0] windows,
    input  logic [DATA_W-1:0]     addr,
    output attr_e                 attr
);
    localparam int unsigned CNT_W = $clog2(NUM_WIN + 1);

    logic [NUM_WIN-1:0] hit;
    logic [CNT_W-1:0]   hit_cnt;
    logic               nsc_any;
    logic [PAGE_W-1:0]  page;

    assign page = addr[DATA_W-1:GRAN_BITS];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        assign hit[g] = windows[g].en
                     && (page >= windows[g].base)
                     && (page <= windows[g].limit);
    end

    always_comb begin
        hit_cnt = '0;
        nsc_any = 1'b0;
        for (int i = 0; i < NUM_WIN; i++) begin
            hit_cnt = hit_cnt + CNT_W'(hit[i]);
            nsc_any = nsc_any | (hit[i] & windows[i].nsc);
        end
    end

    always_comb begin
        if (!unit_en)          attr = all_ns ? ATTR_NSEC : ATTR_SEC;
        else if (hit_cnt == 1) attr = nsc_any ? ATTR_NSC : ATTR_NSEC;
        else                   attr = ATTR_SEC;
    end

    // R3: disabled unit follows the all-non-secure flag only
    a_r3_disabled_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (!unit_en && !all_ns) |-> attr == ATTR_SEC);
    // R9: overlapping windows resolve to Secure
    a_r9_overlap_secure: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_en && $countones(hit) > 1) |-> attr == ATTR_SEC);
    // R9: no window hit resolves to Secure
    a_r9_miss_secure: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_en && hit == '0) |-> attr == ATTR_SEC);
endmodule

// File: rtl/sau_attrib_unit.sv
module sau_attrib_unit
    import sau_pkg::*;
#(
    parameter int unsigned NUM_WIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    output logic              bus_ready,
    input  logic              bus_write,
    input  logic [OFF_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [DATA_W-1:0] lookup_addr,
    output logic [1:0]        lookup_attr
);
    logic                  wr_stb;
    logic [DATA_W-1:0]     rd_data;
    logic                  unit_en;
    logic                  all_ns;
    window_t [NUM_WIN-1:0] windows;
    attr_e                 attr;

    sau_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .rd_data   (rd_data),
        .bus_ready (bus_ready),
        .wr_stb    (wr_stb),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    sau_reg_bank #(.NUM_WIN(NUM_WIN)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rd_data (rd_data),
        .unit_en (unit_en),
        .all_ns  (all_ns),
        .windows (windows)
    );

    sau_lookup #(.NUM_WIN(NUM_WIN)) u_lookup (
        .clk     (clk),
        .rst_n   (rst_n),
        .unit_en (unit_en),
        .all_ns  (all_ns),
        .windows (windows),
        .addr    (lookup_addr),
        .attr    (attr)
    );

    assign lookup_attr = attr;

    // R10: a write to an unmapped offset leaves the control flags alone
    a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && bus_addr != OFF_CTRL) |=> ($stable(unit_en) && $stable(all_ns)));
endmodule

// File: tb/tb_sau_attrib_unit.sv
module tb_sau_attrib_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] lookup_addr = '0;
    logic        bus_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic [1:0]  lookup_attr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    bit          chk_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    sau_attrib_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .lookup_addr(lookup_addr), .lookup_attr(lookup_attr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one scoreboard item per response cycle
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            check("R11 ready low in response", {31'b0, bus_ready}, 32'd0);
            if (exp_q.size() == 0) begin
                check("R11 unexpected response", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                bit c;
                string t;
                e = exp_q.pop_front();
                c = chk_q.pop_front();
                t = tag_q.pop_front();
                if (c) check(t, rsp_rdata, e);
            end
        end
    end

    task automatic xfer(input bit wr, input logic [4:0] a, input logic [31:0] d,
                        input bit chk, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = wr;
        bus_addr  = a;
        bus_wdata = d;
        exp_q.push_back(wr ? 32'd0 : e);
        chk_q.push_back(chk);
        tag_q.push_back(tag);
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
        @(posedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        xfer(1'b1, a, d, 1'b1, 32'd0, "R11 write response data");
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        xfer(1'b0, a, 32'd0, 1'b1, e, tag);
    endtask

    task automatic look(input logic [31:0] a, input logic [1:0] e, input string tag);
        @(negedge clk);
        lookup_addr = a;
        #1;
        check(tag, {30'b0, lookup_attr}, {30'b0, e});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        check("R11 ready after reset", {31'b0, bus_ready}, 32'd1);
        rd(5'h00, 32'h0, "R1 control reset");
        rd(5'h08, 32'h0, "R1 select reset");
        rd(5'h10, 32'h0, "R1 limit flags reset");
        look(32'h1234_5678, 2'b00, "R1 reset lookup Secure");

        rd(5'h04, 32'h4, "R4 type count");
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h04, 32'h4, "R4 type write ignored");

        wr(5'h00, 32'hFFFF_FFFE);
        rd(5'h00, 32'h2, "R2 control reserved bits zero");
        look(32'h0000_0000, 2'b01, "R3 disabled all-non-secure");

        wr(5'h08, 32'h3);
        wr(5'h08, 32'h7);
        rd(5'h08, 32'h3, "R5 select write >=4 ignored");
        wr(5'h0C, 32'h2000_001F);
        rd(5'h0C, 32'h2000_0000, "R6 base low bits zero");
        wr(5'h10, 32'h2000_0FFF);
        rd(5'h10, 32'h2000_0FE3, "R7 limit reserved zero flags kept");

        wr(5'h08, 32'h0);
        wr(5'h0C, 32'h1000_0000);
        wr(5'h10, 32'h1000_00E1);
        wr(5'h08, 32'h1);
        wr(5'h0C, 32'h1000_0080);
        wr(5'h10, 32'h1000_0101);
        rd(5'h0C, 32'h1000_0080, "R6 base of selected window 1");
        wr(5'h08, 32'h4);
        wr(5'h0C, 32'h1000_0080);
        wr(5'h08, 32'h0);
        rd(5'h0C, 32'h1000_0000, "R6 window 0 base untouched");

        wr(5'h14, 32'hFFFF_FFFF);
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h14, 32'h0, "R10 unmapped read zero");
        rd(5'h18, 32'h0, "R10 unmapped write ignored");
        rd(5'h00, 32'h2, "R10 control unchanged by unmapped write");

        wr(5'h00, 32'h1);
        rd(5'h00, 32'h1, "R2 enable bit");
        look(32'h0FFF_FFFF, 2'b00, "R9 no window Secure");
        look(32'h1000_0000, 2'b01, "R8 base inclusive");
        look(32'h1000_007F, 2'b01, "R8 window 0 only");
        look(32'h1000_0080, 2'b00, "R9 overlap low edge Secure");
        look(32'h1000_00FF, 2'b00, "R9 overlap high edge Secure");
        look(32'h1000_0100, 2'b01, "R8 window 1 only");
        look(32'h1000_011F, 2'b01, "R8 limit low bits all ones");
        look(32'h1000_0120, 2'b00, "R8 past limit Secure");
        look(32'h2000_0FFF, 2'b10, "R9 callable window");
        look(32'h2000_1000, 2'b00, "R8 past callable limit");

        wr(5'h08, 32'h1);
        wr(5'h10, 32'h1000_0100);
        look(32'h1000_0080, 2'b01, "R9 single hit after disable");
        look(32'h1000_0100, 2'b00, "R7 disabled window no match");

        wr(5'h00, 32'h0);
        look(32'h1000_0000, 2'b00, "R3 disabled Secure");
        wr(5'h00, 32'h3);
        look(32'h1000_0000, 2'b01, "R3 enabled ignores flag hit");
        look(32'h0000_0000, 2'b00, "R3 enabled ignores flag miss");

        repeat (3) @(posedge clk);
        check("R11 all responses seen", exp_q.size(), 32'd0);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule